// File: doc/BRIEF.md
# Triggered Acquisition FIFO Controller

This block takes a stream of converter samples and stores them in a small FIFO once acquisition has been started. The start can come from a bus write or from a rising edge on an external start pin. An optional delayed mode throws away a fixed number of sample periods after the start, so that samples taken while the converter settles after a clock change never reach the FIFO.

A host reads samples and status through 16-bit accesses at fixed byte offsets. Some offsets act as strobes, where the written value does not matter. A transfer word counter counts FIFO reads while DMA is enabled and raises a terminal-count event when it runs out. The interrupt output combines a FIFO-level source and the terminal-count source. A DMA request output asks an external engine to drain the FIFO.

Top module: `acq_fifo_ctrl`

## Requirements
- R1: After reset the status word at offset 0x12 reads the board ID parameter in bits [9:8] and zero in every flag bit, and both `irq` and `dma_req` are low.
- R2: No sample is stored before a start event. A write of any value to offset 0x06 is a software start, and samples presented after it are stored.
- R3: A rising edge on `ext_start` starts acquisition only while bit 4 of the trigger register (offset 0x02) is 1. With that bit at 0 the edge is ignored.
- R4: Trigger register bits [1:0] select the start mode. Value 3 discards the first 72 samples after the start and stores from the 73rd. Values 0, 1 and 2 store from the first sample after the start.
- R5: Reading offset 0x0A returns the oldest stored sample and removes it, in arrival order. Status bit 0 is 1 while the FIFO holds at least one sample.
- R6: A sample that arrives while the FIFO holds DEPTH (16) samples is dropped. Status bit 3 (overflow) then stays at 1 until a FIFO reset.
- R7: A write of any value to offset 0x08 empties the FIFO, clears overflow and end-of-acquisition, and stops acquisition, so that a new start is needed before samples are stored again.
- R8: Offset 0x04 loads the transfer word count and reads it back. Each sample read from 0x0A while DMA is enabled (control bit 3 at offset 0x12) decrements a nonzero count. Reads with DMA disabled leave the count unchanged. The read that takes the count from 1 to 0 sets status bit 7 (terminal count) and status bit 4 (end of acquisition).
- R9: A write of any value to offset 0x0E clears status bit 7 and leaves status bit 4 set.
- R10: `irq` equals (control bit 8 AND (control bit 9 ? fill >= 8 : FIFO not empty)) OR (control bit 11 AND terminal count). Status bit 6 reads the same value.
- R11: `dma_req` is high when control bit 3 is 1, the transfer count is nonzero, and (control bit 12 ? FIFO not empty : fill >= 8).
- R12: Status bit 5 follows the `conv_cal_busy` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | One-cycle strobe for a new converter sample |
| smp_data | input | 16 | Sample value |
| ext_start | input | 1 | External start, acts on its rising edge |
| conv_cal_busy | input | 1 | Converter offset calibration in progress |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, combinational from the current address |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A wrong start or delay state shows up at the ports as the wrong first sample read from offset 0x0A. With a delay counter off by one, for example, the first value read is 71 or 73 instead of 72. This error is visible at the first read after the start sequence ends. Corrupted FIFO pointers or a lost overflow latch show up within one drain of the FIFO as reordered, missing or extra samples, or as a wrong bit 3. A transfer counter that slips changes the read on which `dma_req` drops and status bit 7 rises, so the error appears on the same cycle as the terminal read.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam logic [4:0] OFS_TRIG  = 5'h02;
  localparam logic [4:0] OFS_XCNT  = 5'h04;
  localparam logic [4:0] OFS_START = 5'h06;
  localparam logic [4:0] OFS_CLR   = 5'h08;
  localparam logic [4:0] OFS_DATA  = 5'h0A;
  localparam logic [4:0] OFS_TCCLR = 5'h0E;
  localparam logic [4:0] OFS_STAT  = 5'h12;

  typedef enum logic [1:0] {
    MODE_PLAIN0 = 2'd0,
    MODE_PLAIN1 = 2'd1,
    MODE_POST   = 2'd2,
    MODE_DELAY  = 2'd3
  } start_mode_e;

  // Packs the status word; bit positions are decoded by host software.
  function automatic logic [15:0] pack_status(input logic [1:0] id,
      input logic nonempty, input logic ovf, input logic eoa,
      input logic cal, input logic intr, input logic tc);
    logic [15:0] s;
    s = '0;
    s[0] = nonempty;
    s[3] = ovf;
    s[4] = eoa;
    s[5] = cal;
    s[6] = intr;
    s[7] = tc;
    s[9:8] = id;
    return s;
  endfunction

  // Level test used by both the interrupt and the DMA request logic.
  function automatic logic at_half(input int unsigned fill, input int unsigned depth);
    return fill >= depth / 2;
  endfunction
endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        push,
  input  logic [W-1:0]                din,
  input  logic                        pop,
  output logic [W-1:0]                dout,
  output logic [$clog2(DEPTH):0]      fill,
  output logic                        empty,
  output logic                        overflow
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, push_ok, pop_ok, push_drop;

  assign full      = fill == (AW+1)'(DEPTH);
  assign empty     = fill == '0;
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign pop_ok    = pop && !empty;
  assign dout      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; fill <= '0; overflow <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0; rd_ptr <= '0; fill <= '0; overflow <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      fill <= fill + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
      if (push_drop) overflow <= 1'b1;
    end
  end

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr |=> overflow);
  a_r7_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty && !overflow);
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop && !pop && !clr |=> fill == $past(fill));
endmodule

// File: rtl/acq_start_gate.sv
module acq_start_gate #(
  parameter int DELAY = 72
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] mode,
  input  logic       hw_en,
  input  logic       sw_start,
  input  logic       ext_start,
  input  logic       smp_valid,
  output logic       store,
  output logic       running
);
  import acq_pkg::*;
  localparam int DW = $clog2(DELAY + 1);
  localparam logic [DW-1:0] DLY_INIT = DW'(DELAY);

  logic          ext_q, ext_rise, start_evt;
  logic [DW-1:0] dly_left;

  assign ext_rise  = ext_start && !ext_q;
  assign start_evt = sw_start || (hw_en && ext_rise);
  assign store     = running && smp_valid && dly_left == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0; running <= 1'b0; dly_left <= '0;
    end else begin
      ext_q <= ext_start;
      if (clr) begin
        running  <= 1'b0;
        dly_left <= '0;
      end else if (!running && start_evt) begin
        running  <= 1'b1;
        dly_left <= (start_mode_e'(mode) == MODE_DELAY) ? DLY_INIT : '0;
      end else if (running && smp_valid && dly_left != '0) begin
        dly_left <= dly_left - 1'b1;
      end
    end
  end

  a_r4_delay_load: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !running && start_evt && mode == 2'd3 |=> dly_left == DLY_INIT);
  a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(start_evt));
endmodule

// File: rtl/acq_xfer_count.sv
module acq_xfer_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  input  logic          tc_clr,
  input  logic          fifo_clr,
  output logic [CW-1:0] count,
  output logic          tc_flag,
  output logic          eoa_flag
);
  logic tc_hit;
  assign tc_hit = dec && count == CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0; tc_flag <= 1'b0; eoa_flag <= 1'b0;
    end else begin
      if (load)                      count <= load_val;
      else if (dec && count != '0)   count <= count - 1'b1;
      if (tc_hit)      tc_flag <= 1'b1;
      else if (tc_clr) tc_flag <= 1'b0;
      if (tc_hit)        eoa_flag <= 1'b1;
      else if (fifo_clr) eoa_flag <= 1'b0;
    end
  end

  a_r8_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> $past(dec && count == CW'(1)));
  a_r9_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tc_clr && !tc_hit |=> !tc_flag);
endmodule

// File: rtl/acq_fifo_ctrl.sv
module acq_fifo_ctrl #(
  parameter int         W        = 16,
  parameter int         DEPTH    = 16,
  parameter int         DELAY    = 72,
  parameter logic [1:0] BOARD_ID = 2'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  input  logic [15:0] smp_data,
  input  logic        ext_start,
  input  logic        conv_cal_busy,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        dma_req
);
  import acq_pkg::*;
  localparam int FW = $clog2(DEPTH) + 1;

  // Register fields
  logic [1:0] trig_mode;
  logic       trig_hw_en;
  logic       dma_en, fifo_ie, half_sel, tc_ie, demand;

  // Named internal events
  logic wr_trig, wr_xcnt, wr_start, wr_clr, wr_tcclr, wr_ctrl, rd_data;
  logic store, running, fifo_empty, fifo_ovf, tc_flag, eoa_flag, half;
  logic [FW-1:0] fill;
  logic [W-1:0]  fifo_dout;
  logic [15:0]   xcnt;

  assign wr_trig  = bus_wr && bus_addr == OFS_TRIG;
  assign wr_xcnt  = bus_wr && bus_addr == OFS_XCNT;
  assign wr_start = bus_wr && bus_addr == OFS_START;
  assign wr_clr   = bus_wr && bus_addr == OFS_CLR;
  assign wr_tcclr = bus_wr && bus_addr == OFS_TCCLR;
  assign wr_ctrl  = bus_wr && bus_addr == OFS_STAT;
  assign rd_data  = bus_rd && bus_addr == OFS_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_mode <= '0; trig_hw_en <= 1'b0;
      dma_en <= 1'b0; fifo_ie <= 1'b0; half_sel <= 1'b0;
      tc_ie <= 1'b0; demand <= 1'b0;
    end else begin
      if (wr_trig) begin
        trig_mode  <= bus_wdata[1:0];
        trig_hw_en <= bus_wdata[4];
      end
      if (wr_ctrl) begin
        dma_en   <= bus_wdata[3];
        fifo_ie  <= bus_wdata[8];
        half_sel <= bus_wdata[9];
        tc_ie    <= bus_wdata[11];
        demand   <= bus_wdata[12];
      end
    end
  end

  acq_start_gate #(.DELAY(DELAY)) u_gate (
    .clk(clk), .rst_n(rst_n), .clr(wr_clr), .mode(trig_mode),
    .hw_en(trig_hw_en), .sw_start(wr_start), .ext_start(ext_start),
    .smp_valid(smp_valid), .store(store), .running(running));

  acq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(wr_clr), .push(store),
    .din(W'(smp_data)), .pop(rd_data), .dout(fifo_dout), .fill(fill),
    .empty(fifo_empty), .overflow(fifo_ovf));

  acq_xfer_count #(.CW(16)) u_xcnt (
    .clk(clk), .rst_n(rst_n), .load(wr_xcnt), .load_val(bus_wdata),
    .dec(rd_data && !fifo_empty && dma_en), .tc_clr(wr_tcclr),
    .fifo_clr(wr_clr), .count(xcnt), .tc_flag(tc_flag), .eoa_flag(eoa_flag));

  assign half    = at_half(int'(fill), DEPTH);
  assign irq     = (fifo_ie && (half_sel ? half : !fifo_empty)) || (tc_ie && tc_flag);
  assign dma_req = dma_en && xcnt != '0 && (demand ? !fifo_empty : half);

  always_comb begin
    case (bus_addr)
      OFS_STAT: bus_rdata = pack_status(BOARD_ID, !fifo_empty, fifo_ovf,
                                        eoa_flag, conv_cal_busy, irq, tc_flag);
      OFS_DATA: bus_rdata = 16'(fifo_dout);
      OFS_TRIG: bus_rdata = {11'd0, trig_hw_en, 2'd0, trig_mode};
      OFS_XCNT: bus_rdata = xcnt;
      default:  bus_rdata = 16'd0;
    endcase
  end

  a_r11_dma_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !fifo_empty);
  a_r7_clr_stops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> !running && !eoa_flag);
  a_r2_idle_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !store);
endmodule

// File: tb/acq_fifo_ctrl_test.sv
module acq_fifo_ctrl_test;
  localparam int DEPTH = 16;
  localparam int DELAY = 72;
  localparam logic [1:0] ID = 2'd1;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, ext_start = 0, conv_cal_busy = 0;
  logic [15:0] smp_data = 0, bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = 0;
  logic [15:0] bus_rdata;
  logic irq, dma_req;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  acq_fifo_ctrl #(.DEPTH(DEPTH), .DELAY(DELAY), .BOARD_ID(ID)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .ext_start(ext_start), .conv_cal_busy(conv_cal_busy), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic samp(input logic [15:0] v);
    @(negedge clk); smp_data = v; smp_valid = 1;
    @(negedge clk); smp_valid = 0;
  endtask

  function automatic logic [15:0] stat(input bit ne, ovf, eoa, cal, ir, tc);
    return (16'(ID) << 8) | (16'(tc) << 7) | (16'(ir) << 6) | (16'(cal) << 5)
         | (16'(eoa) << 4) | (16'(ovf) << 3) | 16'(ne);
  endfunction

  // Drains the FIFO, checking that values run first..first+n-1.
  task automatic drain(input string req, input int first, input int n);
    logic [15:0] s, d;
    int got = 0;
    for (int k = 0; k < DEPTH + 2; k++) begin
      peek(5'h12, s);
      if (s[0]) begin
        rd(5'h0A, d);
        if (got < n) check(req, d, 16'(first + got));
        got++;
      end
    end
    check(req, got, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] s, d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(5'h12, s);
    check("R1 status", s, stat(0,0,0,0,0,0));
    check("R1 irq", irq, 0);
    check("R1 dma_req", dma_req, 0);
    // R12 calibration busy
    conv_cal_busy = 1; peek(5'h12, s);
    check("R12 cal", s[5], 1);
    conv_cal_busy = 0;

    // R2: no storage before start
    wr(5'h02, 16'h0002);
    samp(16'h0055); samp(16'h0056);
    peek(5'h12, s); check("R2 idle no store", s[0], 0);
    wr(5'h06, 16'hBEEF);
    for (int i = 0; i < 5; i++) samp(16'(200 + i));
    drain("R2 R5 sw start order", 200, 5);

    // R7: reset stops acquisition
    wr(5'h08, 16'h1234);
    samp(16'h0077);
    peek(5'h12, s); check("R7 stopped", s[0], 0);

    // R3: hardware start
    wr(5'h02, 16'h0002);
    @(negedge clk); ext_start = 1; @(negedge clk); ext_start = 0;
    samp(16'h0011);
    peek(5'h12, s); check("R3 edge ignored when disabled", s[0], 0);
    wr(5'h02, 16'h0012);
    samp(16'h0012);
    peek(5'h12, s); check("R3 no store before edge", s[0], 0);
    @(negedge clk); ext_start = 1; @(negedge clk); ext_start = 0;
    samp(16'd300); samp(16'd301);
    drain("R3 hw start", 300, 2);

    // R4 R6: sweep all start modes with 74 samples
    for (int m = 0; m < 4; m++) begin
      int exp_n, exp_first;
      bit exp_ovf;
      wr(5'h08, 0);
      wr(5'h02, 16'(m));
      wr(5'h06, 0);
      for (int i = 0; i < DELAY + 2; i++) samp(16'(1000 + i));
      exp_first = (m == 3) ? 1000 + DELAY : 1000;
      exp_n     = (m == 3) ? 2 : DEPTH;
      exp_ovf   = (m == 3) ? 0 : 1;
      peek(5'h12, s);
      check("R6 overflow flag", s[3], exp_ovf);
      drain("R4 R6 mode sweep contents", exp_first, exp_n);
      peek(5'h12, s);
      check("R6 overflow stays after drain", s[3], exp_ovf);
    end
    wr(5'h08, 0);
    peek(5'h12, s);
    check("R7 reset clears", s, stat(0,0,0,0,0,0));

    // R10 interrupt levels
    wr(5'h02, 16'h0002); wr(5'h06, 0);
    wr(5'h12, 16'h0300);
    for (int i = 0; i < DEPTH/2 - 1; i++) samp(16'(i));
    check("R10 below half", irq, 0);
    samp(16'h00AA);
    check("R10 half irq", irq, 1);
    peek(5'h12, s); check("R10 status irq bit", s[6], 1);
    // R11 single mode DMA request at half
    wr(5'h04, 16'd5);
    wr(5'h12, 16'h0008);
    check("R11 single half", dma_req, 1);
    rd(5'h0A, d);
    check("R11 single below half", dma_req, 0);
    wr(5'h08, 0); wr(5'h06, 0);
    wr(5'h12, 16'h0100);
    check("R10 ne irq off empty", irq, 0);
    samp(16'h0001);
    check("R10 ne irq", irq, 1);

    // R8 R9 transfer counter and terminal count
    wr(5'h08, 0); wr(5'h06, 0);
    for (int i = 0; i < 5; i++) samp(16'(500 + i));
    wr(5'h12, 16'h0000);
    wr(5'h04, 16'd2);
    rd(5'h0A, d);
    check("R5 read value", d, 16'd500);
    peek(5'h04, s); check("R8 no dec without dma", s, 16'd2);
    wr(5'h04, 16'd3);
    wr(5'h12, 16'h1808);
    check("R11 demand req", dma_req, 1);
    rd(5'h0A, d); rd(5'h0A, d);
    peek(5'h12, s); check("R8 no tc yet", s[7], 0);
    rd(5'h0A, d);
    check("R8 third value", d, 16'd503);
    peek(5'h12, s);
    check("R8 tc and eoa", s, stat(1,0,1,0,1,1));
    check("R10 tc irq", irq, 1);
    check("R11 req off at zero count", dma_req, 0);
    peek(5'h04, s); check("R8 count zero", s, 16'd0);
    wr(5'h0E, 16'hFFFF);
    peek(5'h12, s);
    check("R9 tc cleared eoa kept", s, stat(1,0,1,0,0,0));
    check("R9 irq drops", irq, 0);
    wr(5'h08, 0);
    peek(5'h12, s); check("R7 eoa cleared", s[4], 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule